// File: doc/BRIEF.md
# Sixteen-Bit Rotate Unit with Carry Ring

This block rotates a 16-bit word in one of four ways. A plain left rotate and a plain right rotate turn the word on itself. The two carry forms turn a 17-bit ring, made of the carry flag above the word, to the left or to the right. A caller offers an operation select, an 8-bit raw count, the word, the current carry flag and the current overflow flag. The unit returns the rotated word, new carry and overflow values, and a write-enable. The write-enable tells the caller whether the destination should be updated.

The raw count comes from whichever source the caller chose, such as an immediate, the constant one or a count register. The unit reduces that count in a different way for each operation family. An effective count of zero makes the whole operation a no-op.

Operations enter through a valid/ready input port and leave through a valid/ready output port, with one register stage between the two. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output holds its value and no new operation is taken in. A producer may hold `in_valid` high for as long as it needs to.

Top module: `rot_unit`

## Requirements
- R1: Op code 2'b00 is a left rotate of the word on itself by raw count bits [3:0]. Carry-out equals result bit 0.
- R2: Op code 2'b01 is a right rotate of the word on itself by raw count bits [3:0]. Carry-out equals result bit 15.
- R3: Op code 2'b10 rotates the 17-bit ring {carry, word} left by (raw count bits [4:0]) modulo 17. Result bit (n-1) receives the old carry, and carry-out is operand bit (16-n).
- R4: Op code 2'b11 rotates the same 17-bit ring right by (raw count bits [4:0]) modulo 17. Result bit (16-n) receives the old carry, and carry-out is operand bit (n-1).
- R5: A left carry-ring rotate by 16 yields the old carry in bit 15 above operand bits [15:1], with carry-out equal to operand bit 0.
- R6: An effective count of zero returns the operand unchanged, passes the carry and overflow inputs through unchanged, and drives the write-enable low. Any nonzero effective count drives the write-enable high.
- R7: Overflow-out equals operand bit 15 XOR result bit 15 only when the effective count is 1. For any other effective count, overflow-out equals overflow-in.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted operation appears on the outputs with `out_valid` high on the next clock edge. While `out_valid` is high and `out_ready` is low, all outputs stay stable.
- R9: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation |
| in_op | input | 2 | 00 left, 01 right, 10 left through carry, 11 right through carry |
| in_word | input | 16 | Operand |
| in_count | input | 8 | Raw rotate count |
| in_cf | input | 1 | Carry flag before the operation |
| in_of | input | 1 | Overflow flag before the operation |
| out_valid | output | 1 | Result held on the outputs |
| out_ready | input | 1 | Consumer takes the result |
| out_word | output | 16 | Rotated word |
| out_wr_en | output | 1 | Destination should be written |
| out_cf | output | 1 | Carry flag after the operation |
| out_of | output | 1 | Overflow flag after the operation |

## Verification
The bench aims at the count reductions that differ by family.

- A raw count of 16 is a no-op for plain rotates but not for carry rotates. A raw count of 17 or 49 is a no-op for carry rotates, and 20 reduces to 4 or to 3 depending on the family. A unit that shared one reduction would write the wrong word or raise the write-enable on a no-op.
- The left carry rotate by 16 and counts of 1 check the carry position and the overflow rule. A misplaced carry bit or an overflow updated at larger counts shows up as a wrong flag.
- A stalled consumer with a second operation waiting checks that a result is neither overwritten nor lost.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    OP_ROL = 2'b00,
    OP_ROR = 2'b01,
    OP_RCL = 2'b10,
    OP_RCR = 2'b11
  } rot_op_e;

  function automatic logic is_ring_op(rot_op_e op);
    return op[1];
  endfunction
endpackage

// File: rtl/rot_count_reduce.sv
module rot_count_reduce
  import rot_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  rot_op_e                  op,
  input  logic [CNT_W-1:0]         raw,
  output logic [$clog2(W+1)-1:0]   eff
);
  localparam int RING  = W + 1;
  localparam int PL_W  = $clog2(W);
  localparam int RC_W  = $clog2(W) + 1;
  localparam int EFF_W = $clog2(W+1);

  logic [RC_W-1:0] ring_masked;
  logic [EFF_W-1:0] ring_eff;
  logic [EFF_W-1:0] plain_eff;

  assign ring_masked = raw[RC_W-1:0];
  assign plain_eff   = EFF_W'(raw[PL_W-1:0]);

  always_comb begin
    if (32'(ring_masked) >= RING)
      ring_eff = EFF_W'(32'(ring_masked) - RING);
    else
      ring_eff = EFF_W'(ring_masked);
  end

  assign eff = is_ring_op(op) ? ring_eff : plain_eff;
endmodule

// File: rtl/rot_datapath.sv
module rot_datapath
  import rot_pkg::*;
#(
  parameter int W = 16
) (
  input  rot_op_e                 op,
  input  logic [$clog2(W+1)-1:0]  eff,
  input  logic [W-1:0]            word,
  input  logic                    cf_i,
  input  logic                    of_i,
  output logic [W-1:0]            res,
  output logic                    cf_o,
  output logic                    of_o,
  output logic                    wr_en
);
  localparam int RING = W + 1;

  logic [2*W-1:0]    dbl_l, dbl_r;
  logic [2*RING-1:0] ring_l, ring_r;
  logic [RING-1:0]   ring;
  logic [W-1:0]      rot_res;
  logic              rot_cf;

  assign ring   = {cf_i, word};
  assign dbl_l  = {word, word} << eff;
  assign dbl_r  = {word, word} >> eff;
  assign ring_l = {ring, ring} << eff;
  assign ring_r = {ring, ring} >> eff;

  always_comb begin
    unique case (op)
      OP_ROL: begin
        rot_res = dbl_l[2*W-1:W];
        rot_cf  = rot_res[0];
      end
      OP_ROR: begin
        rot_res = dbl_r[W-1:0];
        rot_cf  = rot_res[W-1];
      end
      OP_RCL: begin
        rot_res = ring_l[2*RING-2:RING];
        rot_cf  = ring_l[2*RING-1];
      end
      default: begin
        rot_res = ring_r[W-1:0];
        rot_cf  = ring_r[W];
      end
    endcase
  end

  assign wr_en = (eff != '0);
  assign res   = wr_en ? rot_res : word;
  assign cf_o  = wr_en ? rot_cf : cf_i;
  assign of_o  = (eff == 1) ? (word[W-1] ^ rot_res[W-1]) : of_i;
endmodule

// File: rtl/rot_out_stage.sv
module rot_out_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] d_word,
  input  logic         d_wr_en,
  input  logic         d_cf,
  input  logic         d_of,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_word,
  output logic         out_wr_en,
  output logic         out_cf,
  output logic         out_of
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_wr_en <= 1'b0;
      out_cf    <= 1'b0;
      out_of    <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word  <= d_word;
        out_wr_en <= d_wr_en;
        out_cf    <= d_cf;
        out_of    <= d_of;
      end
    end
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) &&
      $stable(out_cf) && $stable(out_of) && $stable(out_wr_en));

  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

// File: rtl/rot_unit.sv
module rot_unit
  import rot_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_op,
  input  logic [W-1:0]     in_word,
  input  logic [CNT_W-1:0] in_count,
  input  logic             in_cf,
  input  logic             in_of,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_word,
  output logic             out_wr_en,
  output logic             out_cf,
  output logic             out_of
);
  localparam int EFF_W = $clog2(W+1);

  rot_op_e          op;
  logic [EFF_W-1:0] eff;
  logic [W-1:0]     d_word;
  logic             d_cf, d_of, d_wr_en;
  logic             accept;

  assign op     = rot_op_e'(in_op);
  assign accept = in_valid && in_ready;

  rot_count_reduce #(.W(W), .CNT_W(CNT_W)) u_cnt (
    .op(op), .raw(in_count), .eff(eff)
  );

  rot_datapath #(.W(W)) u_dp (
    .op(op), .eff(eff), .word(in_word), .cf_i(in_cf), .of_i(in_of),
    .res(d_word), .cf_o(d_cf), .of_o(d_of), .wr_en(d_wr_en)
  );

  rot_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .d_word(d_word), .d_wr_en(d_wr_en), .d_cf(d_cf), .d_of(d_of),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_wr_en(out_wr_en), .out_cf(out_cf), .out_of(out_of)
  );

  // R6
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && eff == '0 |=> !out_wr_en && out_word == $past(in_word) &&
      out_cf == $past(in_cf) && out_of == $past(in_of));

  // R1
  plain_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !in_op[1] |=> $countones(out_word) == $countones($past(in_word)));

  // R3
  ring_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && in_op[1] |=>
      $countones({out_cf, out_word}) == $countones({$past(in_cf), $past(in_word)}));

  // R7
  of_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && eff != 1 |=> out_of == $past(in_of));

  // R8
  accept_show_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);
endmodule

// File: tb/rot_unit_tb.sv
module rot_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = 2'b00;
  logic [15:0] in_word = '0;
  logic [7:0]  in_count = '0;
  logic        in_cf = 1'b0;
  logic        in_of = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_word;
  logic        out_wr_en, out_cf, out_of;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rot_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_count(in_count), .in_cf(in_cf),
    .in_of(in_of), .out_valid(out_valid), .out_ready(out_ready),
    .out_word(out_word), .out_wr_en(out_wr_en), .out_cf(out_cf), .out_of(out_of)
  );

  // returns {wr_en, cf, of, word}; rotation by single bit steps
  function automatic logic [18:0] model(logic [1:0] op, logic [15:0] w,
                                        logic [7:0] cnt, logic cf, logic of);
    int n;
    logic [15:0] r = w;
    logic c = cf;
    logic o = of;
    if (op[1]) n = (cnt % 32) % 17;
    else       n = cnt % 16;
    for (int k = 0; k < n; k++) begin
      case (op)
        2'b00: r = {r[14:0], r[15]};
        2'b01: r = {r[0], r[15:1]};
        2'b10: {c, r} = {r, c};
        default: {c, r} = {r[0], c, r[15:1]};
      endcase
    end
    if (n != 0 && op == 2'b00) c = r[0];
    if (n != 0 && op == 2'b01) c = r[15];
    if (n == 1) o = w[15] ^ r[15];
    return {n != 0, c, o, r};
  endfunction

  task automatic check(string req, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [1:0] op, logic [15:0] w,
                        logic [7:0] cnt, logic cf, logic of);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_word = w; in_count = cnt;
    in_cf = cf; in_of = of; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (!out_valid) begin
      checks++; fails++;
      $display("FAIL %s: actual out_valid 0 expected 1", req);
    end
    check(req, {out_wr_en, out_cf, out_of, out_word}, model(op, w, cnt, cf, of));
  endtask

  task automatic t_reset;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      fails++;
      $display("FAIL R9: actual valid %b ready %b expected 0 1", out_valid, in_ready);
    end
  endtask

  task automatic t_plain;
    run_op("R1 rol by 1", 2'b00, 16'h8001, 8'd1, 1'b0, 1'b0);
    run_op("R1 rol raw 20", 2'b00, 16'h1234, 8'd20, 1'b0, 1'b1);
    run_op("R2 ror by 1", 2'b01, 16'h0001, 8'd1, 1'b0, 1'b0);
    run_op("R2 ror by 7", 2'b01, 16'hA5C3, 8'd7, 1'b1, 1'b0);
  endtask

  task automatic t_ring;
    run_op("R3 rcl by 1", 2'b10, 16'h4000, 8'd1, 1'b1, 1'b0);
    run_op("R3 rcl raw 20", 2'b10, 16'hF00F, 8'd20, 1'b1, 1'b0);
    run_op("R4 rcr by 1", 2'b11, 16'h0001, 8'd1, 1'b1, 1'b0);
    run_op("R4 rcr by 9", 2'b11, 16'h1357, 8'd9, 1'b0, 1'b1);
    run_op("R4 rcr by 16", 2'b11, 16'h8000, 8'd16, 1'b1, 1'b0);
    run_op("R5 rcl by 16", 2'b10, 16'h0003, 8'd16, 1'b1, 1'b0);
    run_op("R5 rcl by 16 c0", 2'b10, 16'hFFFE, 8'd16, 1'b0, 1'b1);
  endtask

  task automatic t_zero;
    run_op("R6 rol raw 16", 2'b00, 16'hBEEF, 8'd16, 1'b1, 1'b1);
    run_op("R6 ror raw 0x80", 2'b01, 16'h1234, 8'h80, 1'b0, 1'b1);
    run_op("R6 rcl raw 17", 2'b10, 16'hCAFE, 8'd17, 1'b1, 1'b0);
    run_op("R6 rcr raw 49", 2'b11, 16'h0F0F, 8'd49, 1'b0, 1'b1);
  endtask

  task automatic t_overflow;
    run_op("R7 rol by 2 keeps of", 2'b00, 16'h4000, 8'd2, 1'b0, 1'b1);
    run_op("R7 rcr by 1 sign", 2'b11, 16'h8000, 8'd1, 1'b0, 1'b1);
  endtask

  task automatic t_stall;
    logic [18:0] ea, eb;
    ea = model(2'b00, 16'h0F00, 8'd4, 1'b0, 1'b0);
    eb = model(2'b11, 16'h00FF, 8'd3, 1'b1, 1'b0);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = 2'b00; in_word = 16'h0F00; in_count = 8'd4;
    in_cf = 1'b0; in_of = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_op = 2'b11; in_word = 16'h00FF; in_count = 8'd3; in_cf = 1'b1;
    checks++;
    if (in_ready !== 1'b0) begin
      fails++;
      $display("FAIL R8: actual in_ready %b expected 0", in_ready);
    end
    @(posedge clk);
    @(negedge clk);
    check("R8 held during stall", {out_wr_en, out_cf, out_of, out_word}, ea);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second after drain", {out_wr_en, out_cf, out_of, out_word}, eb);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin
      fails++;
      $display("FAIL R8: actual out_valid %b expected 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_ring();
    t_zero();
    t_overflow();
    t_stall();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule